// File: doc/BRIEF.md
# Out-of-Order Operand-Capture Issue Pool

This block is a small pool of waiting slots that sits between a dispatch stage and a single functional unit. Dispatch places an operation into any free slot. The operation carries an opcode, a destination tag and two source operands. Each source arrives either with its value, or with only the tag of the result it still waits for. While the operation waits, the pool watches a result broadcast bus. Every pending source whose tag matches the broadcast tag takes the broadcast value.

Slots are not kept in arrival order. In every cycle where the functional unit can accept work, the pool sends it one operation whose two operands are both present. Among the waiting operations, the one in the lowest-numbered slot goes first. That slot is released at the clock edge that ends the issue cycle. Dispatch is refused while every slot is occupied. The functional unit and the renaming logic that produces the tags are outside this block.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is empty. `disp_ready` is 1 and `iss_valid` is 0, whatever the value of `fu_ready`.
- R2: An accepted dispatch stores its opcode, destination tag and both source tag, data and valid fields in the lowest-numbered free slot. When that slot later issues, `iss_op`, `iss_dst_tag`, `iss_data1` and `iss_data2` carry the stored operation and its operand values.
- R3: A pending (not valid) source in an occupied slot captures the data when `bc_valid` is high and `bc_tag` equals its tag. It counts as valid from the next cycle on.
- R4: A source that is already valid keeps its data when a broadcast arrives, even if the tags are equal.
- R5: A dispatched source marked not valid captures the data when its tag matches a broadcast in the same cycle. It is then valid from the next cycle, exactly as if the data had arrived with the dispatch.
- R6: `iss_valid` is high exactly when `fu_ready` is high and at least one occupied slot has both sources valid. A slot whose last operand is captured in a cycle cannot issue before the next cycle.
- R7: When several slots are ready, the lowest-numbered one issues, regardless of the order in which they were dispatched.
- R8: An issued slot is free from the next cycle. It cannot take a dispatch in the cycle in which it issues.
- R9: `disp_ready` is low exactly when all slots are occupied. A dispatch offered while `disp_ready` is low is dropped and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | A free slot exists; an offer is taken this cycle |
| disp_op | input | OP_W | Opcode of the dispatched operation |
| disp_src1_tag | input | TAG_W | Producer tag of source 1 |
| disp_src1_data | input | DATA_W | Value of source 1 when valid |
| disp_src1_valid | input | 1 | Source 1 value is present |
| disp_src2_tag | input | TAG_W | Producer tag of source 2 |
| disp_src2_data | input | DATA_W | Value of source 2 when valid |
| disp_src2_valid | input | 1 | Source 2 value is present |
| disp_dst_tag | input | TAG_W | Tag of the result this operation produces |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_data | input | DATA_W | Value of the broadcast result |
| fu_ready | input | 1 | Functional unit accepts an operation this cycle |
| iss_valid | output | 1 | An operation goes to the unit this cycle |
| iss_op | output | OP_W | Issued opcode |
| iss_data1 | output | DATA_W | Issued source 1 value |
| iss_data2 | output | DATA_W | Issued source 2 value |
| iss_dst_tag | output | TAG_W | Destination tag of the issued operation |

## Verification
A broadcast can coincide with a dispatch whose pending source names the broadcast tag. The same broadcast can also coincide with the issue of another slot, or with a dispatch into a full pool while a slot issues. The bench provokes each of these on purpose. It sends a broadcast in the dispatch cycle, and it offers a dispatch in the cycle that empties a full pool's first slot. A reference model in the bench then predicts, per cycle, which slot is granted and which values it carries. A missed bypass shows up as a wrong `iss_data1`. A slot reused too early shows up as a wrong `disp_ready` or a wrong issue order. The random phase draws tags from a narrow range, so these collisions keep recurring.

// File: rtl/rs_pkg.sv
package rs_pkg;
   localparam int unsigned RS_MAX_ENT = 64;
   localparam int unsigned RS_N_SRC   = 2;
endpackage

// File: rtl/rs_lowest_pick.sv
module rs_lowest_pick #(
   parameter int unsigned N   = 4,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !any) begin
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rs_operand_slot.sv
module rs_operand_slot #(
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_valid,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic [TAG_W-1:0]  tag_q,
   output logic [DATA_W-1:0] data_q,
   output logic              valid_q
);
   logic hit_load, hit_wait;

   assign hit_load = bc_valid && (bc_tag == ld_tag);
   assign hit_wait = bc_valid && !valid_q && (bc_tag == tag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q   <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
      end else if (load) begin
         tag_q <= ld_tag;
         if (ld_valid) begin
            data_q  <= ld_data;
            valid_q <= 1'b1;
         end else if (hit_load) begin
            data_q  <= bc_data;
            valid_q <= 1'b1;
         end else begin
            valid_q <= 1'b0;
         end
      end else if (hit_wait) begin
         data_q  <= bc_data;
         valid_q <= 1'b1;
      end
   end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
   parameter int unsigned OP_W   = 4,
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              release_i,
   input  logic [OP_W-1:0]   in_op,
   input  logic [TAG_W-1:0]  in_dst,
   input  logic [TAG_W-1:0]  in_tag   [rs_pkg::RS_N_SRC],
   input  logic [DATA_W-1:0] in_data  [rs_pkg::RS_N_SRC],
   input  logic              in_valid [rs_pkg::RS_N_SRC],
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   output logic              busy_q,
   output logic              ready,
   output logic [OP_W-1:0]   op_q,
   output logic [TAG_W-1:0]  dst_q,
   output logic [TAG_W-1:0]  tag_q    [rs_pkg::RS_N_SRC],
   output logic [DATA_W-1:0] data_q   [rs_pkg::RS_N_SRC],
   output logic              valid_q  [rs_pkg::RS_N_SRC]
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= '0;
         dst_q  <= '0;
      end else if (alloc) begin
         busy_q <= 1'b1;
         op_q   <= in_op;
         dst_q  <= in_dst;
      end else if (release_i) begin
         busy_q <= 1'b0;
      end
   end

   for (genvar s = 0; s < rs_pkg::RS_N_SRC; s++) begin : g_src
      rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (alloc),
         .ld_tag   (in_tag[s]),
         .ld_data  (in_data[s]),
         .ld_valid (in_valid[s]),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .bc_data  (bc_data),
         .tag_q    (tag_q[s]),
         .data_q   (data_q[s]),
         .valid_q  (valid_q[s])
      );
   end

   always_comb begin
      ready = busy_q;
      for (int s = 0; s < rs_pkg::RS_N_SRC; s++) ready = ready && valid_q[s];
   end
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
   parameter int unsigned NUM_ENT = 4,
   parameter int unsigned OP_W    = 4,
   parameter int unsigned TAG_W   = 4,
   parameter int unsigned DATA_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   output logic              disp_ready,
   input  logic [OP_W-1:0]   disp_op,
   input  logic [TAG_W-1:0]  disp_src1_tag,
   input  logic [DATA_W-1:0] disp_src1_data,
   input  logic              disp_src1_valid,
   input  logic [TAG_W-1:0]  disp_src2_tag,
   input  logic [DATA_W-1:0] disp_src2_data,
   input  logic              disp_src2_valid,
   input  logic [TAG_W-1:0]  disp_dst_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_data,
   input  logic              fu_ready,
   output logic              iss_valid,
   output logic [OP_W-1:0]   iss_op,
   output logic [DATA_W-1:0] iss_data1,
   output logic [DATA_W-1:0] iss_data2,
   output logic [TAG_W-1:0]  iss_dst_tag
);
   localparam int unsigned IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
   localparam int unsigned NS = rs_pkg::RS_N_SRC;

   if (NUM_ENT < 2 || NUM_ENT > rs_pkg::RS_MAX_ENT) begin : g_bad_depth
      $error("rs_pool: NUM_ENT out of range");
   end
   if (OP_W < 1 || TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("rs_pool: widths must be positive");
   end

   logic [NUM_ENT-1:0] busy, rdy, free_gnt, iss_gnt, alloc_v, rel_v;
   logic [IW-1:0]      free_idx, iss_idx;
   logic               free_any, rdy_any;

   logic [TAG_W-1:0]  d_tag   [NS];
   logic [DATA_W-1:0] d_data  [NS];
   logic              d_valid [NS];

   logic [OP_W-1:0]   e_op    [NUM_ENT];
   logic [TAG_W-1:0]  e_dst   [NUM_ENT];
   logic [TAG_W-1:0]  e_tag   [NUM_ENT][NS];
   logic [DATA_W-1:0] e_data  [NUM_ENT][NS];
   logic              e_valid [NUM_ENT][NS];

   assign d_tag[0]   = disp_src1_tag;
   assign d_tag[1]   = disp_src2_tag;
   assign d_data[0]  = disp_src1_data;
   assign d_data[1]  = disp_src2_data;
   assign d_valid[0] = disp_src1_valid;
   assign d_valid[1] = disp_src2_valid;

   rs_lowest_pick #(.N(NUM_ENT)) u_free_pick (
      .req (~busy),
      .gnt (free_gnt),
      .idx (free_idx),
      .any (free_any)
   );

   rs_lowest_pick #(.N(NUM_ENT)) u_iss_pick (
      .req (rdy),
      .gnt (iss_gnt),
      .idx (iss_idx),
      .any (rdy_any)
   );

   assign disp_ready = free_any;
   assign iss_valid  = fu_ready && rdy_any;
   assign alloc_v    = disp_valid ? free_gnt : '0;
   assign rel_v      = fu_ready ? iss_gnt : '0;

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      rs_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (alloc_v[i]),
         .release_i (rel_v[i]),
         .in_op     (disp_op),
         .in_dst    (disp_dst_tag),
         .in_tag    (d_tag),
         .in_data   (d_data),
         .in_valid  (d_valid),
         .bc_valid  (bc_valid),
         .bc_tag    (bc_tag),
         .bc_data   (bc_data),
         .busy_q    (busy[i]),
         .ready     (rdy[i]),
         .op_q      (e_op[i]),
         .dst_q     (e_dst[i]),
         .tag_q     (e_tag[i]),
         .data_q    (e_data[i]),
         .valid_q   (e_valid[i])
      );
   end

   assign iss_op      = e_op[iss_idx];
   assign iss_dst_tag = e_dst[iss_idx];
   assign iss_data1   = e_data[iss_idx][0];
   assign iss_data2   = e_data[iss_idx][1];

   logic [NUM_ENT-1:0] v1_vec, v2_vec, t1_hit, t2_hit;
   always_comb begin
      for (int i = 0; i < NUM_ENT; i++) begin
         v1_vec[i] = e_valid[i][0];
         v2_vec[i] = e_valid[i][1];
         t1_hit[i] = (e_tag[i][0] == bc_tag);
         t2_hit[i] = (e_tag[i][1] == bc_tag);
      end
   end
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
   parameter int unsigned NUM_ENT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               disp_valid,
   input logic               disp_ready,
   input logic               fu_ready,
   input logic               iss_valid,
   input logic               bc_valid,
   input logic [NUM_ENT-1:0] busy,
   input logic [NUM_ENT-1:0] iss_gnt,
   input logic [NUM_ENT-1:0] v1_vec,
   input logic [NUM_ENT-1:0] v2_vec,
   input logic [NUM_ENT-1:0] t1_hit,
   input logic [NUM_ENT-1:0] t2_hit
);
   AST_ISSUE_NEEDS_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> fu_ready); // R6

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(iss_gnt)); // R7

   AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy) |-> !disp_ready); // R9

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ((&busy) && !iss_valid) |=> (&busy)); // R9

   AST_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> ((busy & $past(iss_gnt)) == '0)); // R8

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_cap
      AST_CAPTURE_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
         (bc_valid && busy[i] && !v1_vec[i] && t1_hit[i]) |=> v1_vec[i]); // R3
      AST_CAPTURE_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
         (bc_valid && busy[i] && !v2_vec[i] && t2_hit[i]) |=> v2_vec[i]); // R3
      AST_VALID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (busy[i] && v1_vec[i] && !iss_gnt[i]) |=> v1_vec[i]); // R4
   end
endmodule

bind rs_pool rs_pool_chk #(.NUM_ENT(NUM_ENT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .disp_valid (disp_valid),
   .disp_ready (disp_ready),
   .fu_ready   (fu_ready),
   .iss_valid  (iss_valid),
   .bc_valid   (bc_valid),
   .busy       (busy),
   .iss_gnt    (iss_gnt),
   .v1_vec     (v1_vec),
   .v2_vec     (v2_vec),
   .t1_hit     (t1_hit),
   .t2_hit     (t2_hit)
);

// File: tb/sim_rs_pool.sv
`timescale 1ns/1ps
module sim_rs_pool;
   localparam int NE = 4;
   localparam int OW = 4;
   localparam int TW = 4;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic disp_valid = 0, disp_src1_valid = 0, disp_src2_valid = 0;
   logic [OW-1:0] disp_op = '0;
   logic [TW-1:0] disp_src1_tag = '0, disp_src2_tag = '0, disp_dst_tag = '0, bc_tag = '0;
   logic [DW-1:0] disp_src1_data = '0, disp_src2_data = '0, bc_data = '0;
   logic bc_valid = 0, fu_ready = 0;
   logic disp_ready, iss_valid;
   logic [OW-1:0] iss_op;
   logic [DW-1:0] iss_data1, iss_data2;
   logic [TW-1:0] iss_dst_tag;

   int checks = 0, errors = 0;
   bit done = 0;

   logic          m_busy [NE];
   logic [OW-1:0] m_op   [NE];
   logic [TW-1:0] m_dst  [NE];
   logic [TW-1:0] m_t1 [NE], m_t2 [NE];
   logic [DW-1:0] m_d1 [NE], m_d2 [NE];
   logic          m_v1 [NE], m_v2 [NE];

   always #10 clk = ~clk;

   rs_pool #(.NUM_ENT(NE), .OP_W(OW), .TAG_W(TW), .DATA_W(DW)) u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int first_free();
      for (int i = 0; i < NE; i++) if (!m_busy[i]) return i;
      return -1;
   endfunction

   function automatic int first_ready();
      for (int i = 0; i < NE; i++) if (m_busy[i] && m_v1[i] && m_v2[i]) return i;
      return -1;
   endfunction

   task automatic cyc(input string lbl,
                      input bit dv, input logic [OW-1:0] op,
                      input logic [TW-1:0] t1, input logic [DW-1:0] d1, input bit v1,
                      input logic [TW-1:0] t2, input logic [DW-1:0] d2, input bit v2,
                      input logic [TW-1:0] dst,
                      input bit bv, input logic [TW-1:0] bt, input logic [DW-1:0] bd,
                      input bit fu);
      int ff, rk;
      @(negedge clk);
      disp_valid = dv; disp_op = op; disp_dst_tag = dst;
      disp_src1_tag = t1; disp_src1_data = d1; disp_src1_valid = v1;
      disp_src2_tag = t2; disp_src2_data = d2; disp_src2_valid = v2;
      bc_valid = bv; bc_tag = bt; bc_data = bd; fu_ready = fu;
      #1;
      ff = first_free();
      rk = first_ready();
      chk(disp_ready == (ff >= 0), {"R9 disp_ready ", lbl}, 32'(disp_ready), 32'(ff >= 0));
      chk(iss_valid == (fu && rk >= 0), {"R6 iss_valid ", lbl}, 32'(iss_valid), 32'(fu && rk >= 0));
      if (fu && rk >= 0 && iss_valid) begin
         chk(iss_op == m_op[rk] && iss_dst_tag == m_dst[rk], {"R7 op/dst ", lbl},
             {iss_op, 12'h0, iss_dst_tag}, {m_op[rk], 12'h0, m_dst[rk]});
         chk(iss_data1 == m_d1[rk], {"R2 data1 ", lbl}, 32'(iss_data1), 32'(m_d1[rk]));
         chk(iss_data2 == m_d2[rk], {"R2 data2 ", lbl}, 32'(iss_data2), 32'(m_d2[rk]));
      end
      // model update at the coming edge
      for (int i = 0; i < NE; i++) begin
         if (bv && m_busy[i] && !m_v1[i] && m_t1[i] == bt) begin m_d1[i] = bd; m_v1[i] = 1; end
         if (bv && m_busy[i] && !m_v2[i] && m_t2[i] == bt) begin m_d2[i] = bd; m_v2[i] = 1; end
      end
      if (fu && rk >= 0) m_busy[rk] = 0;
      if (dv && ff >= 0) begin
         m_busy[ff] = 1; m_op[ff] = op; m_dst[ff] = dst;
         m_t1[ff] = t1; m_t2[ff] = t2;
         m_v1[ff] = v1 || (bv && bt == t1); m_d1[ff] = v1 ? d1 : bd;
         m_v2[ff] = v2 || (bv && bt == t2); m_d2[ff] = v2 ? d2 : bd;
      end
   endtask

   task automatic idle(input string lbl, input bit fu);
      cyc(lbl, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, fu);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NE; i++) begin
         m_busy[i] = 0; m_v1[i] = 0; m_v2[i] = 0;
         m_op[i] = 0; m_dst[i] = 0; m_t1[i] = 0; m_t2[i] = 0; m_d1[i] = 0; m_d2[i] = 0;
      end
      fu_ready = 1;
      #35;
      // R1: reset state seen at the ports while reset is held
      chk(disp_ready === 1'b1, "R1 disp_ready in reset", 32'(disp_ready), 1);
      chk(iss_valid === 1'b0, "R1 iss_valid in reset", 32'(iss_valid), 0);
      rst_n = 1;
      idle("R1", 1);
      // R7: slot 0 waits on tag 3, slot 1 ready; slot 1 goes first
      cyc("R7", 1, 4'h1, 4'd3, 16'h0, 0, 4'd9, 16'h0909, 1, 4'd1, 0, 0, 0, 0);
      cyc("R7", 1, 4'h2, 4'd8, 16'h0808, 1, 4'd9, 16'h0919, 1, 4'd2, 0, 0, 0, 0);
      cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      // R3 and R6: broadcast with unit free, nothing issues this cycle
      cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd3, 16'hAAAA, 1);
      idle("R3", 1);
      // R4: valid source with tag 2 ignores broadcast of tag 2
      cyc("R4", 1, 4'h3, 4'd2, 16'h1111, 1, 4'd4, 16'h0, 0, 4'd3, 0, 0, 0, 0);
      cyc("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd2, 16'h2222, 0);
      cyc("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd4, 16'h4444, 0);
      idle("R4", 1);
      // R5: dispatch bypass from same-cycle broadcast
      cyc("R5", 1, 4'h4, 4'd6, 16'h0, 0, 4'd1, 16'h5151, 1, 4'd4, 1, 4'd6, 16'h6666, 0);
      idle("R5", 1);
      // R9 and R8: fill, refuse when full, then dispatch in the cycle slot 0 issues
      for (int k = 0; k < NE; k++)
         cyc("R9 fill", 1, OW'(5 + k), 4'd7, 16'h0, 0, 4'd1, 16'(k), 1, TW'(k), 0, 0, 0, 0);
      cyc("R9 full", 1, 4'hF, 4'd1, 16'hDEAD, 1, 4'd1, 16'hBEEF, 1, 4'hF, 0, 0, 0, 1);
      cyc("R9 full", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'd7, 16'h7777, 0);
      cyc("R8", 1, 4'hE, 4'd1, 16'hCAFE, 1, 4'd1, 16'hF00D, 1, 4'hE, 0, 0, 0, 1);
      cyc("R8", 1, 4'hD, 4'd1, 16'h1234, 1, 4'd1, 16'h5678, 1, 4'hD, 0, 0, 0, 1);
      for (int k = 0; k < 6; k++) idle("R8 drain", 1);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         cyc("rand",
             ($urandom % 10) < 6, OW'($urandom), TW'($urandom % 6), DW'($urandom), ($urandom % 10) < 4,
             TW'($urandom % 6), DW'($urandom), ($urandom % 10) < 4, TW'($urandom),
             ($urandom % 2) == 1, TW'($urandom % 6), DW'($urandom), ($urandom % 10) < 7);
      end
      for (int k = 0; k < 8; k++) idle("drain", 1);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule